// File: doc/BRIEF.md
# Signal-Loss Alarm Monitor

This block watches a received clock and its serial data line. It raises two sticky alarms: one for loss of clock and one for loss of data. The whole block runs from an independent reference clock, so a monitored clock that stops can still be seen. The monitored clock, the monitored data and the alarm-reset pin enter through a synchroniser chain of `SYNC_STAGES` flops. Detection works on the synchronised copies, so the reference clock must run well above the monitored clock.

One alarm-reset pin drives both polling and clearing. Only its falling edges count. The first fall is a poll. It restarts both detection intervals and keeps the alarms as they are. A second fall within `WIN_CYCLES` reference cycles clears both alarms. If the window expires first, the next fall is treated as a fresh poll. A clear restarts the detection intervals. An alarm whose fault is still present therefore comes back after one full interval, not at once.

The control machine has four states:
- `ST_IDLE`: waiting.
- `ST_POLL`: one cycle, restarts the intervals.
- `ST_WAIT2`: the window for a second fall is open.
- `ST_CLEAR`: one cycle, clears the alarms and restarts the intervals.

Its transitions are:
- `ST_IDLE`→`ST_POLL` on a fall.
- `ST_POLL`→`ST_WAIT2` always.
- `ST_WAIT2`→`ST_CLEAR` on a fall.
- `ST_WAIT2`→`ST_IDLE` when the window runs out.
- `ST_CLEAR`→`ST_IDLE` always.

Top module: `sig_loss_monitor`

## Requirements
- R1: After reset both alarm outputs are low and the control machine is in `ST_IDLE`.
- R2: `loc_alarm` rises once the synchronised monitored clock shows no edge, rising or falling, for `CLK_LIMIT` reference cycles. It stays low while the monitored clock toggles with a half period well under that limit.
- R3: Once high, `loc_alarm` stays high after the monitored clock resumes, until a clear.
- R4: `lod_alarm` rises once `DATA_LIMIT` rising edges of the monitored clock pass with no transition on the data line. It stays low when the data changes more often than that.
- R5: Once high, `lod_alarm` stays high after data transitions resume, until a clear.
- R6: A single falling edge of `alarm_rst` (a poll) restarts both detection intervals and leaves both alarm outputs unchanged.
- R7: Two falling edges of `alarm_rst` no more than `WIN_CYCLES` reference cycles apart drive both alarms low. With healthy inputs they then stay low.
- R8: A second falling edge that arrives after the `WIN_CYCLES` window has expired is a new poll and clears nothing.
- R9: A clear issued while a fault persists drops the alarm. The alarm reasserts only after a complete new detection interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, independent of the monitored clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored clock, sampled as data |
| mon_data | input | 1 | Monitored serial data line |
| alarm_rst | input | 1 | Alarm poll/clear pin, asynchronous; falling edges are counted |
| loc_alarm | output | 1 | Sticky loss-of-clock alarm |
| lod_alarm | output | 1 | Sticky loss-of-data alarm |

## Verification
The bench draws clock stalls and data runs at random, each either clearly shorter or clearly longer than its limit. The expected alarm comes from a bench function, so a limit that is off by a large margin, or a watcher that misses an edge, shows up as a wrong alarm. Directed cases aim at the control pin:
- A lone pulse that clears would break stickiness.
- A late second pulse that still clears shows a window that never expires.
- A clear while the clock is still dead either leaves the alarm high, if the fault beats the clear, or keeps it low forever, if the interval is not restarted.

// File: rtl/sig_loss_pkg.sv
package sig_loss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_WAIT2 = 2'd2,
        ST_CLEAR = 2'd3
    } alm_state_e;

    localparam int SIG_CLK  = 0;
    localparam int SIG_DATA = 1;
    localparam int SIG_ARST = 2;
    localparam int NUM_SIGS = 3;

endpackage

// File: rtl/alm_sync.sv
module alm_sync #(
    parameter int W           = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[SYNC_STAGES-1];

endmodule

// File: rtl/alm_edge.sv
module alm_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic [W-1:0] any
);

    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = prev & ~sig;
    assign any  = sig ^ prev;

endmodule

// File: rtl/alm_act_watch.sv
module alm_act_watch #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic activity,
    output logic fault
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || activity) begin
            cnt <= '0;
        end else if (tick && (cnt != CAP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fault = (cnt == CAP);

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP); // R2
    AST_ACT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !fault); // R4
    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0)); // R9

endmodule

// File: rtl/alm_ctrl.sv
module alm_ctrl
    import sig_loss_pkg::*;
#(
    parameter int WIN_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arst_fall,
    input  logic loc_fault,
    input  logic lod_fault,
    output logic restart,
    output logic loc_alarm,
    output logic lod_alarm
);

    localparam int WW = $clog2(WIN_CYCLES + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);

    alm_state_e    state, state_nx;
    logic [WW-1:0] win_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (arst_fall) state_nx = ST_POLL;
            ST_POLL:  state_nx = ST_WAIT2;
            ST_WAIT2: begin
                if (arst_fall)                  state_nx = ST_CLEAR;
                else if (win_cnt == WIN_LAST)   state_nx = ST_IDLE;
            end
            ST_CLEAR: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // window counter, runs only while a second fall is awaited
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 win_cnt <= '0;
        else if (state != ST_WAIT2) win_cnt <= '0;
        else if (win_cnt != WIN_LAST) win_cnt <= win_cnt + 1'b1;
    end

    // outputs: sticky alarms, clear has priority over a fresh fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_alarm <= 1'b0;
            lod_alarm <= 1'b0;
        end else if (state == ST_CLEAR) begin
            loc_alarm <= 1'b0;
            lod_alarm <= 1'b0;
        end else begin
            loc_alarm <= loc_alarm | loc_fault;
            lod_alarm <= lod_alarm | lod_fault;
        end
    end

    assign restart = (state == ST_POLL) || (state == ST_CLEAR);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (state == ST_IDLE)); // R1
    AST_LOC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_fault && state != ST_CLEAR) |=> loc_alarm); // R2
    AST_LOC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_alarm && state != ST_CLEAR) |=> loc_alarm); // R3
    AST_LOD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (lod_fault && state != ST_CLEAR) |=> lod_alarm); // R4
    AST_LOD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lod_alarm && state != ST_CLEAR) |=> lod_alarm); // R5
    AST_POLL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL) |=> (state == ST_WAIT2)); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (!loc_alarm && !lod_alarm)); // R7
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt <= WIN_LAST)); // R8
    AST_CLEAR_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nx == ST_CLEAR) |-> (state == ST_WAIT2)); // R8

endmodule

// File: rtl/sig_loss_monitor.sv
module sig_loss_monitor
    import sig_loss_pkg::*;
#(
    parameter int CLK_LIMIT   = 16,
    parameter int DATA_LIMIT  = 8,
    parameter int WIN_CYCLES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic mon_data,
    input  logic alarm_rst,
    output logic loc_alarm,
    output logic lod_alarm
);

    logic [NUM_SIGS-1:0] raw, synced, rise, fall, any;
    logic restart, loc_fault, lod_fault;

    always_comb begin
        raw           = '0;
        raw[SIG_CLK]  = mon_clk;
        raw[SIG_DATA] = mon_data;
        raw[SIG_ARST] = alarm_rst;
    end

    alm_sync #(.W(NUM_SIGS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    alm_edge #(.W(NUM_SIGS)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (synced),
        .rise  (rise),
        .fall  (fall),
        .any   (any)
    );

    // clock watcher: one tick per reference cycle, any monitored edge is activity
    alm_act_watch #(.LIMIT(CLK_LIMIT)) u_clk_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick     (1'b1),
        .activity (any[SIG_CLK]),
        .fault    (loc_fault)
    );

    // data watcher: one tick per monitored bit period, a data change is activity
    alm_act_watch #(.LIMIT(DATA_LIMIT)) u_data_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick     (rise[SIG_CLK]),
        .activity (any[SIG_DATA]),
        .fault    (lod_fault)
    );

    alm_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arst_fall (fall[SIG_ARST]),
        .loc_fault (loc_fault),
        .lod_fault (lod_fault),
        .restart   (restart),
        .loc_alarm (loc_alarm),
        .lod_alarm (lod_alarm)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!loc_alarm && !lod_alarm)); // R1

endmodule

// File: tb/sig_loss_monitor_bench.sv
module sig_loss_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MON_HALF   = 4 * CLK_PERIOD;
    localparam int CLK_LIMIT  = 16;
    localparam int DATA_LIMIT = 8;
    localparam int WIN_CYCLES = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic mon_data = 1'b0;
    logic alarm_rst = 1'b0;
    logic loc_alarm, lod_alarm;
    logic mon_run = 1'b1;
    logic data_hold = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    sig_loss_monitor #(
        .CLK_LIMIT(CLK_LIMIT), .DATA_LIMIT(DATA_LIMIT),
        .WIN_CYCLES(WIN_CYCLES), .SYNC_STAGES(2)
    ) u_sig_loss_monitor (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_data(mon_data),
        .alarm_rst(alarm_rst), .loc_alarm(loc_alarm), .lod_alarm(lod_alarm)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        #(MON_HALF);
        if (mon_run) mon_clk = ~mon_clk;
    end

    initial forever begin
        @(negedge mon_clk);
        if (!data_hold) mon_data = ~mon_data;
    end

    function automatic logic exp_loc(int stall_cycles);
        return (stall_cycles >= CLK_LIMIT);
    endfunction

    function automatic logic exp_lod(int still_bits);
        return (still_bits >= DATA_LIMIT);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse;
        @(negedge clk) alarm_rst = 1'b1;
        wait_ref(4);
        alarm_rst = 1'b0;
        wait_ref(4);
    endtask

    task automatic do_clear(input string req);
        pulse();
        pulse();
        wait_ref(20);
        chk(req, loc_alarm, 1'b0);
        chk(req, lod_alarm, 1'b0);
    endtask

    task automatic stall_clock(input int n);
        mon_run = 1'b0;
        repeat (n) @(posedge clk);
        mon_run = 1'b1;
        wait_ref(12);
    endtask

    task automatic hold_data(input int n);
        data_hold = 1'b1;
        repeat (n) @(posedge mon_clk);
        data_hold = 1'b0;
        repeat (2) @(posedge mon_clk);
        wait_ref(4);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h1A2B3C4D);
        wait_ref(5);
        rst_n = 1'b1;
        wait_ref(3);
        chk("R1", loc_alarm, 1'b0);
        chk("R1", lod_alarm, 1'b0);
        wait_ref(40);
        chk("R2", loc_alarm, 1'b0);
        chk("R4", lod_alarm, 1'b0);

        // random stalls and still data runs
        for (int it = 0; it < 16; it++) begin
            int kind, n;
            do_clear("R7");
            kind = int'($urandom_range(3, 0));
            case (kind)
                0: begin
                    n = int'($urandom_range(CLK_LIMIT - 8, 1));
                    stall_clock(n);
                    chk("R2 short stall", loc_alarm, exp_loc(n));
                end
                1: begin
                    n = int'($urandom_range(CLK_LIMIT + 20, CLK_LIMIT + 4));
                    stall_clock(n);
                    chk("R2 long stall", loc_alarm, exp_loc(n));
                end
                2: begin
                    n = int'($urandom_range(DATA_LIMIT - 3, 1));
                    hold_data(n);
                    chk("R4 short run", lod_alarm, exp_lod(n));
                end
                default: begin
                    n = int'($urandom_range(DATA_LIMIT + 6, DATA_LIMIT + 2));
                    hold_data(n);
                    chk("R4 long run", lod_alarm, exp_lod(n));
                end
            endcase
        end

        // R3 / R5 stickiness after recovery
        do_clear("R7");
        stall_clock(CLK_LIMIT + 10);
        wait_ref(60);
        chk("R3 sticky loc", loc_alarm, 1'b1);
        hold_data(DATA_LIMIT + 4);
        wait_ref(80);
        chk("R5 sticky lod", lod_alarm, 1'b1);

        // R6 single pulse keeps both alarms
        pulse();
        wait_ref(10);
        chk("R6 poll loc", loc_alarm, 1'b1);
        chk("R6 poll lod", lod_alarm, 1'b1);
        wait_ref(WIN_CYCLES + 20);
        chk("R6 after window", loc_alarm, 1'b1);

        // R8 second pulse after the window is only a poll
        pulse();
        wait_ref(WIN_CYCLES + 20);
        pulse();
        wait_ref(10);
        chk("R8 late loc", loc_alarm, 1'b1);
        chk("R8 late lod", lod_alarm, 1'b1);
        wait_ref(WIN_CYCLES + 20);

        // R7 clear with healthy inputs, stays low
        do_clear("R7");
        wait_ref(100);
        chk("R7 stays low", loc_alarm, 1'b0);
        chk("R7 stays low", lod_alarm, 1'b0);

        // R9 clear while clock is still dead
        mon_run = 1'b0;
        wait_ref(CLK_LIMIT + 10);
        chk("R9 set", loc_alarm, 1'b1);
        pulse();
        @(negedge clk) alarm_rst = 1'b1;
        wait_ref(4);
        alarm_rst = 1'b0;
        wait_ref(8);
        chk("R9 dropped", loc_alarm, 1'b0);
        wait_ref(CLK_LIMIT + 4);
        chk("R9 reasserted", loc_alarm, 1'b1);
        mon_run = 1'b1;
        wait_ref(20);
        do_clear("R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule